// File: doc/BRIEF.md
# Indirect-Address Serial Flash Bridge with Follow Mode

This block lets a processor reach a serial flash through a small byte-wide register window. Four index registers hold a 32-bit indirect address, and one data register starts the actual flash traffic. In normal mode, reading the data register runs a complete serial read: chip select falls, the read opcode and a 24-bit offset taken from the lower three index bytes go out, one byte comes back, and chip select rises again. The byte returned is the flash contents at that offset.

Writing the code 0xF into the low nibble of the top index register switches the bridge into follow mode. In this mode the index value is no longer a flash address. It selects what a data-register access does to the serial pins. With the middle index bytes set to FF/FD, chip select is held low: each data write shifts one byte out, and each data read shifts one byte in and returns it. With FF/FE, a data access raises chip select. Software therefore builds arbitrary command frames one byte at a time, and only the second index byte changes between the low and high selections. Clearing the low nibble of the top index register returns the bridge to normal mode.

The register side uses a valid/ready handshake. The requester raises `reg_valid` with a stable `reg_write`, `reg_addr` and `reg_wdata`, and holds them until `reg_ready` is high at a rising clock edge. Read data on `reg_rdata` is valid in that handshake cycle. The bridge holds `reg_ready` low for as long as a serial byte is shifting, which is the wait that back-pressures the processor.

Top module: `spi_follow_bridge`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high, `spi_sck` is low, follow mode is off, and all four index registers read 0x00.
- R2: A write to offsets 0..3 stores the byte in index register 0..3, a read from offsets 0..3 returns it, and both complete in the cycle they are presented (`reg_ready` high at once).
- R3: Follow mode is active exactly while the low nibble of index register 3 is 0xF, and writing that nibble to any other value leaves follow mode.
- R4: In normal mode, a read of the data register (offset 4) drives chip select low, sends 0x03 and then index bytes 2, 1 and 0, receives one byte, raises chip select, and returns that byte.
- R5: While a serial byte is shifting, `reg_ready` is low. The request completes only after the last byte of its frame has finished.
- R6: In follow mode with index bytes 2/1 equal to 0xFF/0xFE, a data access raises chip select without clocking, returns 0x00 on a read, and completes at once.
- R7: In follow mode with index bytes 2/1 equal to 0xFF/0xFD, a data write drives chip select low and shifts the written byte out, and chip select stays low after the access.
- R8: In follow mode with index bytes 2/1 equal to 0xFF/0xFD, a data read shifts out the filler byte 0x00 and returns the byte sampled from `spi_miso`.
- R9: In normal mode a data write is ignored: no clock edges, chip select unchanged, immediate completion.
- R10: In follow mode with any other index bytes 2/1, a data access makes no clock edges, leaves chip select unchanged, returns 0x00, and completes at once.
- R11: The serial format is mode 0, MSB first: `spi_sck` idles low and pulses only while chip select is low. Each byte has 8 rising edges, and each half period lasts HALF_DIV clocks. MISO is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register request valid |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Offset: 0..3 index bytes, 4 data register |
| reg_wdata | input | 8 | Write data |
| reg_ready | output | 1 | Request accepted this cycle; low = wait |
| reg_rdata | output | 8 | Read data, valid with the handshake |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions assume that a requester holds its request fields stable and keeps `reg_valid` high from the cycle it is raised until `reg_ready` completes the handshake. They also assume that the index registers do not change while a frame is shifting, which holds because index writes wait on the same handshake. The bench's bus task drives a request at a falling edge and holds it until it sees `reg_ready`. It drops `reg_valid` only after the accepting rising edge, so both assumptions hold for every random and directed access. Random flash offsets never put 0xF in the low nibble of index register 3 during normal-mode reads, so the follow-mode phases are entered only on purpose.

// File: rtl/spib_pkg.sv
package spib_pkg;
  localparam int BYTE_W    = 8;
  localparam int IDX_REGS  = 4;
  localparam int IDX_W     = BYTE_W * IDX_REGS;
  localparam int OFS_W     = 3;

  localparam logic [OFS_W-1:0]  OFS_DATA    = 3'd4;
  localparam logic [BYTE_W-1:0] OP_READ     = 8'h03;
  localparam logic [BYTE_W-1:0] FILL_BYTE   = 8'h00;
  localparam logic [3:0]        FOLLOW_CODE = 4'hF;
  localparam logic [BYTE_W-1:0] SEL_PAGE    = 8'hFF;
  localparam logic [BYTE_W-1:0] SEL_CS_LOW  = 8'hFD;
  localparam logic [BYTE_W-1:0] SEL_CS_HIGH = 8'hFE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_SHIFT,
    ST_FIN
  } ctrl_st_t;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_CS_HIGH,
    ACT_FOLLOW_SHIFT,
    ACT_FLASH_READ
  } act_t;
endpackage

// File: rtl/spib_index_regs.sv
module spib_index_regs #(
  parameter int NUM_REGS = 4,
  parameter int BYTE_W   = 8,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [SEL_W-1:0]             sel,
  input  logic [BYTE_W-1:0]            wdata,
  output logic [NUM_REGS*BYTE_W-1:0]   idx
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
    logic [BYTE_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         r_q <= '0;
      else if (we && sel == SEL_W'(i))    r_q <= wdata;
    end
    assign idx[i*BYTE_W +: BYTE_W] = r_q;
  end
endmodule

// File: rtl/spib_byte_engine.sv
module spib_byte_engine #(
  parameter int HALF_DIV = 2,
  parameter int BYTE_W   = 8,
  localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1,
  localparam int BIT_W   = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic              sck_q, busy_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; bit_q <= '0; tx_q <= '0; rx_q <= '0;
      sck_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        tx_q   <= tx;
        bit_q  <= '0;
        div_q  <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q) begin
        if (div_q == DIV_W'(HALF_DIV - 1)) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[BYTE_W-2:0], miso};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == BIT_W'(BYTE_W - 1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;
  assign sck  = sck_q;
  assign mosi = tx_q[BYTE_W-1];

  assert_clock_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> busy_q);
  assert_start_when_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  assert_done_ends_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!sck_q && !busy_q));
endmodule

// File: rtl/spib_ctrl.sv
module spib_ctrl
  import spib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_ready,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [IDX_W-1:0]  idx,
  output logic              idx_we,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [BYTE_W-1:0] eng_rx,
  output logic              eng_start,
  output logic [BYTE_W-1:0] eng_tx,
  output logic              cs_n
);
  ctrl_st_t          st_q;
  act_t              act;
  logic              follow, is_data, is_idx, sel_low, sel_high;
  logic [2:0]        left_q;
  logic              flash_q;
  logic [BYTE_W-1:0] tx_q, rx_q, idx_byte;
  logic              cs_q;

  assign follow   = (idx[27:24] == FOLLOW_CODE);
  assign is_data  = (reg_addr == OFS_DATA);
  assign is_idx   = (reg_addr < OFS_W'(IDX_REGS));
  assign sel_low  = (idx[23:16] == SEL_PAGE) && (idx[15:8] == SEL_CS_LOW);
  assign sel_high = (idx[23:16] == SEL_PAGE) && (idx[15:8] == SEL_CS_HIGH);

  always_comb begin
    act = ACT_NONE;
    if (is_data) begin
      if (follow) begin
        if (sel_high)     act = ACT_CS_HIGH;
        else if (sel_low) act = ACT_FOLLOW_SHIFT;
      end else if (!reg_write) begin
        act = ACT_FLASH_READ;
      end
    end
  end

  always_comb begin
    case (reg_addr[1:0])
      2'd0:    idx_byte = idx[7:0];
      2'd1:    idx_byte = idx[15:8];
      2'd2:    idx_byte = idx[23:16];
      default: idx_byte = idx[31:24];
    endcase
  end

  always_comb begin
    reg_ready = 1'b0;
    reg_rdata = '0;
    if (st_q == ST_IDLE) begin
      reg_ready = reg_valid && (act == ACT_NONE || act == ACT_CS_HIGH);
      if (is_idx) reg_rdata = idx_byte;
    end else if (st_q == ST_FIN) begin
      reg_ready = 1'b1;
      reg_rdata = rx_q;
    end
  end

  assign idx_we    = (st_q == ST_IDLE) && reg_valid && reg_write && is_idx;
  assign eng_start = (st_q == ST_ISSUE);
  assign eng_tx    = tx_q;
  assign cs_n      = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; left_q <= '0; flash_q <= 1'b0;
      tx_q <= '0; rx_q <= '0; cs_q <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: if (reg_valid) begin
          case (act)
            ACT_CS_HIGH: cs_q <= 1'b1;
            ACT_FOLLOW_SHIFT: begin
              cs_q    <= 1'b0;
              tx_q    <= reg_write ? reg_wdata : FILL_BYTE;
              left_q  <= '0;
              flash_q <= 1'b0;
              st_q    <= ST_ISSUE;
            end
            ACT_FLASH_READ: begin
              cs_q    <= 1'b0;
              tx_q    <= OP_READ;
              left_q  <= 3'd4;
              flash_q <= 1'b1;
              st_q    <= ST_ISSUE;
            end
            default: ;
          endcase
        end
        ST_ISSUE: st_q <= ST_SHIFT;
        ST_SHIFT: if (eng_done) begin
          rx_q <= eng_rx;
          if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            case (left_q)
              3'd4:    tx_q <= idx[23:16];
              3'd3:    tx_q <= idx[15:8];
              3'd2:    tx_q <= idx[7:0];
              default: tx_q <= FILL_BYTE;
            endcase
            st_q <= ST_ISSUE;
          end else begin
            if (flash_q) cs_q <= 1'b1;
            st_q <= ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_wait_while_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !reg_ready);
  assert_index_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && reg_valid && is_idx) |-> reg_ready);
  assert_release_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIN && flash_q) |-> cs_q);
  assert_cs_held_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIN && !flash_q) |-> !cs_q);
  assert_normal_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && reg_valid && reg_write && is_data && !follow)
      |=> (st_q == ST_IDLE && $stable(cs_q)));
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !(reg_valid && is_data)) |=> $stable(cs_q));
endmodule

// File: rtl/spi_follow_bridge.sv
module spi_follow_bridge
  import spib_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic              reg_ready,
  output logic [7:0]        reg_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic [IDX_W-1:0]  idx;
  logic              idx_we, eng_busy, eng_done, eng_start;
  logic [BYTE_W-1:0] eng_rx, eng_tx;

  spib_index_regs #(.NUM_REGS(IDX_REGS), .BYTE_W(BYTE_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .we(idx_we), .sel(reg_addr[1:0]),
    .wdata(reg_wdata), .idx(idx)
  );

  spib_byte_engine #(.HALF_DIV(HALF_DIV), .BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx(eng_tx),
    .busy(eng_busy), .done(eng_done), .rx(eng_rx),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  spib_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .idx(idx), .idx_we(idx_we),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_rx(eng_rx),
    .eng_start(eng_start), .eng_tx(eng_tx), .cs_n(spi_cs_n)
  );

  assert_clock_needs_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);
endmodule

// File: tb/sim_spi_follow_bridge.sv
module sim_spi_follow_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int BYTE_CYC   = 2 * HALF_DIV * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_ready, spi_sck, spi_cs_n, spi_mosi;
  logic [7:0] reg_rdata;
  logic spi_miso = 1'b0;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_follow_bridge #(.HALF_DIV(HALF_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
    .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- flash model ----------------
  logic [7:0] frame_bytes [16];
  int frame_bits = 0;
  int sck_rises = 0;
  logic [7:0] sh = '0;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] slave_byte(input int k);
    logic [23:0] a;
    if (k >= 4 && frame_bytes[0] == 8'h03) begin
      a = {frame_bytes[1], frame_bytes[2], frame_bytes[3]} + 24'(k - 4);
      return mem_byte(a);
    end
    return 8'hC0 ^ 8'(k);
  endfunction

  always @(negedge spi_cs_n) begin
    frame_bits = 0;
    spi_miso = slave_byte(0)[7];
  end

  always @(posedge spi_sck) begin
    logic [7:0] nb;
    sck_rises++;
    if (!spi_cs_n) begin
      sh = {sh[6:0], spi_mosi};
      frame_bits++;
      if (frame_bits % 8 == 0) frame_bytes[(frame_bits/8 - 1) & 15] = sh;
      nb = slave_byte(frame_bits / 8);
      spi_miso = nb[7 - (frame_bits % 8)];
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [2:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output int cyc);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_wdata = d;
    #1;
    cyc = 0;
    while (!reg_ready) begin
      @(negedge clk); #1; cyc++;
    end
    rd = reg_rdata;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic set_idx(input logic [7:0] b3, input logic [7:0] b2,
                         input logic [7:0] b1, input logic [7:0] b0);
    logic [7:0] rd; int c;
    bus(1'b1, 3'd3, b3, rd, c);
    bus(1'b1, 3'd2, b2, rd, c);
    bus(1'b1, 3'd1, b1, rd, c);
    bus(1'b1, 3'd0, b0, rd, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R5 actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd, b0, b1, b2, b3, wb [3];
    int cyc, s0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(spi_cs_n === 1'b1, "R1 cs_n", spi_cs_n, 1);
    check(spi_sck === 1'b0, "R1 sck", spi_sck, 0);
    for (int i = 0; i < 4; i++) begin
      bus(1'b0, 3'(i), 8'h00, rd, cyc);
      check(rd === 8'h00, "R1 index reset", rd, 0);
      check(cyc == 0, "R2 index read no wait", cyc, 0);
    end

    // R2 index write/readback, random
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < 4; i++) begin
        b0 = 8'($urandom);
        bus(1'b1, 3'(i), b0, rd, cyc);
        check(cyc == 0, "R2 index write no wait", cyc, 0);
        bus(1'b0, 3'(i), 8'h00, rd, cyc);
        check(rd === b0, "R2 index readback", rd, b0);
      end
    end

    // R4/R5 normal reads at random offsets
    for (int n = 0; n < 16; n++) begin
      b3 = {4'($urandom), 4'($urandom_range(0, 14))};
      b2 = 8'($urandom); b1 = 8'($urandom); b0 = 8'($urandom);
      if (n == 0) begin b2 = 8'hFF; b1 = 8'hFF; b0 = 8'hFF; end
      if (n == 1) begin b2 = 8'hFF; b1 = 8'hFD; b0 = 8'h00; end
      set_idx(b3, b2, b1, b0);
      s0 = sck_rises;
      bus(1'b0, 3'd4, 8'h00, rd, cyc);
      check(rd === mem_byte({b2, b1, b0}), "R4 flash byte", rd, mem_byte({b2, b1, b0}));
      check(frame_bytes[0] === 8'h03 && frame_bytes[1] === b2 &&
            frame_bytes[2] === b1 && frame_bytes[3] === b0, "R4 frame header",
            {frame_bytes[0], frame_bytes[1], frame_bytes[2], frame_bytes[3]},
            {8'h03, b2, b1, b0});
      check(sck_rises - s0 == 40, "R11 rising edges per read", sck_rises - s0, 40);
      check(cyc >= 5 * BYTE_CYC, "R5 wait spans frame", cyc, 5 * BYTE_CYC);
      check(spi_cs_n === 1'b1, "R4 cs released", spi_cs_n, 1);
    end

    // R9 normal-mode data write ignored
    s0 = sck_rises;
    bus(1'b1, 3'd4, 8'hA5, rd, cyc);
    check(cyc == 0, "R9 immediate", cyc, 0);
    check(sck_rises == s0, "R9 no clocks", sck_rises - s0, 0);
    check(spi_cs_n === 1'b1, "R9 cs unchanged", spi_cs_n, 1);

    // R3/R7/R8 follow mode frame
    set_idx(8'h4F, 8'hFF, 8'hFD, 8'h00);
    for (int k = 0; k < 3; k++) begin
      wb[k] = 8'($urandom);
      s0 = sck_rises;
      bus(1'b1, 3'd4, wb[k], rd, cyc);
      check(sck_rises - s0 == 8, "R7 eight edges", sck_rises - s0, 8);
      check(cyc >= BYTE_CYC, "R5 follow write waits", cyc, BYTE_CYC);
      check(spi_cs_n === 1'b0, "R7 cs stays low", spi_cs_n, 0);
    end
    for (int k = 0; k < 3; k++)
      check(frame_bytes[k] === wb[k], "R7 byte shifted out", frame_bytes[k], wb[k]);
    for (int k = 3; k < 5; k++) begin
      bus(1'b0, 3'd4, 8'h00, rd, cyc);
      check(rd === (8'hC0 ^ 8'(k)), "R8 follow read value", rd, 8'hC0 ^ 8'(k));
      check(frame_bytes[k] === 8'h00, "R8 filler out", frame_bytes[k], 0);
    end

    // R10 other address in follow mode
    bus(1'b1, 3'd1, 8'h12, rd, cyc);
    s0 = sck_rises;
    bus(1'b0, 3'd4, 8'h00, rd, cyc);
    check(rd === 8'h00 && cyc == 0, "R10 read zero at once", rd, 0);
    bus(1'b1, 3'd4, 8'h77, rd, cyc);
    check(sck_rises == s0, "R10 no clocks", sck_rises - s0, 0);
    check(spi_cs_n === 1'b0, "R10 cs unchanged", spi_cs_n, 0);

    // R6 raise chip select
    bus(1'b1, 3'd1, 8'hFE, rd, cyc);
    s0 = sck_rises;
    bus(1'b1, 3'd4, 8'h00, rd, cyc);
    check(spi_cs_n === 1'b1, "R6 cs raised", spi_cs_n, 1);
    check(cyc == 0 && sck_rises == s0, "R6 no clocks no wait", sck_rises - s0, 0);
    bus(1'b0, 3'd4, 8'h00, rd, cyc);
    check(rd === 8'h00, "R6 read zero", rd, 0);

    // R3 exit follow mode: data read becomes a flash read again
    bus(1'b1, 3'd1, 8'hFD, rd, cyc);
    bus(1'b1, 3'd3, 8'h40, rd, cyc);
    bus(1'b1, 3'd2, 8'h00, rd, cyc);
    s0 = sck_rises;
    bus(1'b0, 3'd4, 8'h00, rd, cyc);
    check(sck_rises - s0 == 40, "R3 normal after exit", sck_rises - s0, 40);
    check(rd === mem_byte({8'h00, 8'hFD, 8'h00}), "R3 flash byte after exit",
          rd, mem_byte({8'h00, 8'hFD, 8'h00}));
    check(spi_sck === 1'b0, "R11 sck idles low", spi_sck, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule